// File: doc/BRIEF.md
# Execute-Stage ALU with Parity Self-Check and Spare Path

This block is the arithmetic and logic unit of a processor's execute stage. It computes six bitwise operations, add and subtract with carry, and three kinds of shift. The bitwise set is AND, NAND, OR, NOR, XOR and XNOR. A one-cycle output register closes the stage. A second copy of the datapath runs beside the first. Only the parity of that copy's output is kept, and it is compared with the parity of the primary output. The parity of each operand is also checked against a parity bit that arrives with the operand. Any mismatch raises a single error flag for the recovery logic.

The block can swap in a replacement unit. The operands and the operation code always leave the block unchanged on a spare-facing port set. A select input picks between the internal result and the result that comes back from the spare unit. While the spare is selected, the internal checks are masked, so a primary unit already known to be bad cannot start another recovery.

Top module: `alu_selfcheck`

## Requirements
- R1: Operation codes 0 to 5 give AND, NAND, OR, NOR, XOR and XNOR of `opa` and `opb`, with `carry` 0.
- R2: Code 6 gives `opa + opb`, with `carry` the carry out of bit 31. Code 7 gives `opa - opb`, with `carry` 1 exactly when `opa >= opb` as unsigned numbers, meaning no borrow occurred.
- R3: Code 8 shifts `opa` left logically, code 9 shifts it right logically and code 10 shifts it right arithmetically. In each case the shift amount is `opb[4:0]` and `carry` is 0. Codes 11 to 15 give result 0 and carry 0.
- R4: Operand parity is even: `opa_par` must equal the XOR of all bits of `opa`, and `opb_par` must do the same for `opb`. A mismatch on either operand sets `err` in the next cycle, provided `spare_sel` is 0.
- R5: With correct operand parity and `spare_sel` 0, the duplicate unit's predicted output parity agrees with the primary unit's, and `err` stays 0.
- R6: `spare_opa`, `spare_opb` and `spare_op` equal `opa`, `opb` and `op_code` at all times, whatever the value of `spare_sel`.
- R7: With `spare_sel` 1, `result` and `carry` in the next cycle equal `spare_result` and `spare_carry`.
- R8: With `spare_sel` 1, `err` in the next cycle is 0, even when the operand parity is wrong.
- R9: `result`, `carry` and `err` are registered and appear one cycle after their inputs. While `rst_n` is low, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_code | input | 4 | Operation select (see R1 to R3) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand; bits 4:0 are the shift amount |
| opa_par | input | 1 | Even-parity bit of `opa` |
| opb_par | input | 1 | Even-parity bit of `opb` |
| spare_sel | input | 1 | 1 selects the spare unit's result |
| spare_result | input | 32 | Result returned by the spare unit |
| spare_carry | input | 1 | Carry returned by the spare unit |
| spare_opa | output | 32 | First operand sent to the spare unit |
| spare_opb | output | 32 | Second operand sent to the spare unit |
| spare_op | output | 4 | Operation code sent to the spare unit |
| result | output | 32 | Registered result |
| carry | output | 1 | Registered carry |
| err | output | 1 | Registered check error for the recovery logic |

## Verification
The assertions assume that operands, parity bits and the spare inputs are stable across each sampling edge. They also assume that the only way `err` can be raised on a fault-free design is a wrong operand parity bit. The bench changes all inputs on the falling edge. Each operand parity bit is computed from its operand and then deliberately flipped for about one item in eight. This produces both clean and corrupt inputs, so that the "no error" and "error" assertions each see real traffic. The spare select is raised on a random fraction of cycles, together with wrong parity, to exercise the masking rule.

// File: rtl/alu_selfcheck_pkg.sv
package alu_selfcheck_pkg;
    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_NAND = 4'd1,
        OP_OR   = 4'd2,
        OP_NOR  = 4'd3,
        OP_XOR  = 4'd4,
        OP_XNOR = 4'd5,
        OP_ADD  = 4'd6,
        OP_SUB  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10
    } alu_op_e;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_selfcheck_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             co
);
    localparam int SHW = $clog2(WIDTH);

    logic [WIDTH:0]   add_w;
    logic [WIDTH:0]   sub_w;
    logic [SHW-1:0]   amt;

    always_comb begin
        add_w = {1'b0, a} + {1'b0, b};
        sub_w = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
        amt   = b[SHW-1:0];
        y     = '0;
        co    = 1'b0;
        case (op)
            OP_AND:  y = a & b;
            OP_NAND: y = ~(a & b);
            OP_OR:   y = a | b;
            OP_NOR:  y = ~(a | b);
            OP_XOR:  y = a ^ b;
            OP_XNOR: y = ~(a ^ b);
            OP_ADD:  {co, y} = add_w;
            OP_SUB:  {co, y} = sub_w;
            OP_SLL:  y = a << amt;
            OP_SRL:  y = a >> amt;
            OP_SRA:  y = WIDTH'($signed(a) >>> amt);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/parity_tree.sv
module parity_tree #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] d,
    output logic             p
);
    assign p = ^d;
endmodule

// File: rtl/alu_selfcheck.sv
module alu_selfcheck
    import alu_selfcheck_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             opa_par,
    input  logic             opb_par,
    input  logic             spare_sel,
    input  logic [WIDTH-1:0] spare_result,
    input  logic             spare_carry,
    output logic [WIDTH-1:0] spare_opa,
    output logic [WIDTH-1:0] spare_opb,
    output logic [3:0]       spare_op,
    output logic [WIDTH-1:0] result,
    output logic             carry,
    output logic             err
);
    localparam int NOPS = 2;

    logic [WIDTH-1:0] main_y, dup_y;
    logic             main_co, dup_co;
    logic             main_par, dup_par;
    logic [WIDTH-1:0] ops [NOPS];
    logic [NOPS-1:0]  par_in, par_calc;
    logic             in_bad, out_bad;

    assign spare_opa = opa;
    assign spare_opb = opb;
    assign spare_op  = op_code;

    alu_datapath #(.WIDTH(WIDTH)) u_main (
        .op(op_code), .a(opa), .b(opb), .y(main_y), .co(main_co)
    );
    alu_datapath #(.WIDTH(WIDTH)) u_dup (
        .op(op_code), .a(opa), .b(opb), .y(dup_y), .co(dup_co)
    );

    parity_tree #(.WIDTH(WIDTH+1)) u_pmain (.d({main_co, main_y}), .p(main_par));
    parity_tree #(.WIDTH(WIDTH+1)) u_pdup  (.d({dup_co, dup_y}),   .p(dup_par));

    assign ops[0] = opa;
    assign ops[1] = opb;
    assign par_in = {opb_par, opa_par};

    for (genvar g = 0; g < NOPS; g++) begin : g_opchk
        parity_tree #(.WIDTH(WIDTH)) u_pin (.d(ops[g]), .p(par_calc[g]));
    end

    assign in_bad  = |(par_calc ^ par_in);
    assign out_bad = main_par ^ dup_par;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            carry  <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (spare_sel) begin
                result <= spare_result;
                carry  <= spare_carry;
                err    <= 1'b0;
            end else begin
                result <= main_y;
                carry  <= main_co;
                err    <= in_bad | out_bad;
            end
        end
    end

    // R7
    spare_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spare_sel |=> (result == $past(spare_result) && carry == $past(spare_carry)));

    // R8
    spare_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spare_sel |=> !err);

    // R4
    opa_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spare_sel && (opa_par != ^opa)) |=> err);

    // R5
    clean_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spare_sel && opa_par == ^opa && opb_par == ^opb) |=> !err);

    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spare_sel && op_code == OP_ADD) |=>
            ({carry, result} == {1'b0, $past(opa)} + {1'b0, $past(opb)}));

    // R1
    xnor_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spare_sel && op_code == OP_XNOR) |=> (result == ~($past(opa) ^ $past(opb)) && !carry));
endmodule

// File: tb/sim_alu_selfcheck.sv
`timescale 1ns/1ps
module sim_alu_selfcheck;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opa = '0, opb = '0, spare_result = '0;
    logic        opa_par = 1'b0, opb_par = 1'b0, spare_sel = 1'b0, spare_carry = 1'b0;
    logic [31:0] spare_opa, spare_opb, result;
    logic [3:0]  spare_op;
    logic        carry, err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [32:0] exp_cr;
    logic        exp_err;

    always #5 clk = ~clk;

    alu_selfcheck u0 (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opa(opa), .opb(opb),
        .opa_par(opa_par), .opb_par(opb_par), .spare_sel(spare_sel),
        .spare_result(spare_result), .spare_carry(spare_carry),
        .spare_opa(spare_opa), .spare_opb(spare_opb), .spare_op(spare_op),
        .result(result), .carry(carry), .err(err)
    );

    function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] r;
        int sh;
        sh = int'(b[4:0]);
        case (op)
            4'd0: r = {1'b0, a & b};
            4'd1: r = {1'b0, ~(a & b)};
            4'd2: r = {1'b0, a | b};
            4'd3: r = {1'b0, ~(a | b)};
            4'd4: r = {1'b0, a ^ b};
            4'd5: r = {1'b0, ~(a ^ b)};
            4'd6: r = {1'b0, a} + {1'b0, b};
            4'd7: r = {(a >= b) ? 1'b1 : 1'b0, a - b};
            4'd8: r = {1'b0, a << sh};
            4'd9: r = {1'b0, a >> sh};
            4'd10: begin
                r = {1'b0, a >> sh};
                for (int i = 0; i < 32; i++) if (i >= 32 - sh && a[31]) r[i] = 1'b1;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // drive on falling edge, outputs checked one falling edge later
    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input bit flip_a, input bit flip_b, input bit sel,
                         input logic [31:0] sres, input logic sc, input string tag);
        op_code = op; opa = a; opb = b;
        opa_par = (^a) ^ flip_a; opb_par = (^b) ^ flip_b;
        spare_sel = sel; spare_result = sres; spare_carry = sc;
        #1;
        // R6
        check("R6", {spare_op, spare_opa, spare_opb[27:0]}, {op, a, b[27:0]});
        exp_cr  = sel ? {sc, sres} : model(op, a, b);
        exp_err = !sel && (flip_a || flip_b);
        @(negedge clk);
        check(tag, {31'd0, carry, result}, {31'd0, exp_cr});
        check(sel ? "R8" : (flip_a || flip_b) ? "R4" : "R5", {63'd0, err}, {63'd0, exp_err});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", {31'd0, carry, result}, 64'd0);
        check("R9", {63'd0, err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        apply(4'd0, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 0, '0, 0, "R1");
        apply(4'd3, 32'h0000_0000, 32'h0000_0001, 0, 0, 0, '0, 0, "R1");
        apply(4'd6, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, '0, 0, "R2");
        apply(4'd7, 32'h0000_0005, 32'h0000_0005, 0, 0, 0, '0, 0, "R2");
        apply(4'd7, 32'h0000_0004, 32'h0000_0005, 0, 0, 0, '0, 0, "R2");
        apply(4'd10, 32'h8000_0000, 32'h0000_001F, 0, 0, 0, '0, 0, "R3");
        apply(4'd9, 32'h8000_0000, 32'hFFFF_FFE4, 0, 0, 0, '0, 0, "R3");
        apply(4'd8, 32'h1234_5678, 32'h0000_0000, 0, 0, 0, '0, 0, "R3");
        apply(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, '0, 0, "R3");
        apply(4'd4, 32'hAAAA_AAAA, 32'h1, 1, 0, 0, '0, 0, "R1");
        apply(4'd4, 32'hAAAA_AAAA, 32'h1, 0, 1, 0, '0, 0, "R1");
        apply(4'd6, 32'h1, 32'h2, 1, 1, 1, 32'hDEAD_BEEF, 1, "R7");
        // R9 latency: a new input must not show before the edge
        op_code = 4'd2; opa = 32'h1; opb = 32'h2; opa_par = 1'b1; opb_par = 1'b1; spare_sel = 1'b0;
        #1;
        check("R9", {31'd0, carry, result}, {31'd0, 1'b1, 32'hDEAD_BEEF});
        @(negedge clk);
        check("R9", {31'd0, carry, result}, 64'd3);
        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [3:0]  op;
            logic [31:0] a, b, sr;
            bit fa, fb, sel;
            op  = 4'($urandom_range(0, 15));
            a   = $urandom;
            b   = $urandom;
            sr  = $urandom;
            fa  = ($urandom_range(0, 7) == 0);
            fb  = ($urandom_range(0, 7) == 0);
            sel = ($urandom_range(0, 4) == 0);
            apply(op, a, b, fa, fb, sel, sr, 1'($urandom_range(0, 1)),
                  sel ? "R7" : (op < 4'd6) ? "R1" : (op < 4'd8) ? "R2" : "R3");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule